// File: doc/BRIEF.md
# PWM Output Software Force Controller

This block sits between a two-channel PWM action generator and the output pins. Software uses it to override either channel, A or B, in two ways. The first is a one-shot force. Software flips a per-channel trigger bit, and the chosen level is latched into that channel's output state. The level then stays until the generator next changes its own output. The second is a continuous force. It is written into a shadow copy and copied into an active copy at chosen moments: at once, on selected timer and sync event strobes, or never (frozen). While an active continuous force is low or high, it overrides the channel completely.

The control word is 16 bits wide and is written through a simple write-enable port. The readback port always shows the last written word, that is, the shadow contents.

Top module: `pwm_force_ctrl`

## Requirements
- R1: After reset the control word reads as zero. No force is active, and each output follows its generator input with one clock of latency.
- R2: A write with `wr_en` high is returned on `rd_data` after the next rising clock edge.
- R3: Every 2-bit force mode decodes as follows: 1 forces low, 2 forces high, and 0 or 3 apply no force.
- R4: A one-shot force fires when a write changes the channel's trigger bit, in either direction. Channel A uses bit 10 with its mode in bits 12:11. Channel B uses bit 13 with its mode in bits 15:14. A write that keeps the trigger bit unchanged fires nothing.
- R5: A one-shot force latches its level into the channel's output state on the clock edge that takes the write. The level holds until the generator input changes, after which the output again follows the generator.
- R6: When the update field (bits 5:0) of the word being written is zero, the written continuous modes become active on the same clock edge that stores the write. The continuous mode for A is in bits 7:6 and the mode for B is in bits 9:8.
- R7: When the update field is nonzero, the shadowed continuous modes are copied to the active copy only on an enabled event strobe. The enables are: bit 0 for timer zero, bit 1 for period, bit 2 for compare A, bit 3 for compare B, and bit 4 for sync. A strobe whose bit is clear does nothing.
- R8: Several enabled strobes in the same cycle cause exactly one copy, with the same result as a single strobe.
- R9: Update bit 5 freezes the active continuous modes, even when other enable bits are set.
- R10: An active continuous low or high overrides both the generator input and any one-shot result. Removing it reveals the channel's latched output state.
- R11: The readback shows the written shadow modes, even while the active modes still differ from them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 16 | Control word write data |
| gen_a | input | 1 | Raw generator output, channel A |
| gen_b | input | 1 | Raw generator output, channel B |
| ev_zero | input | 1 | Timer-equals-zero strobe |
| ev_period | input | 1 | Timer-equals-period strobe |
| ev_cmpa | input | 1 | Timer-equals-compare-A strobe |
| ev_cmpb | input | 1 | Timer-equals-compare-B strobe |
| ev_sync | input | 1 | Sync strobe |
| pwm_a | output | 1 | Final output level, channel A |
| pwm_b | output | 1 | Final output level, channel B |
| rd_data | output | 16 | Control word readback (shadow contents) |

## Verification
The trigger bit is flipped upward and downward, and also rewritten with its unchanged value. This separates toggle detection from plain "written as 1" detection. Each event strobe is pulsed alone, first with a different enable bit set and then with its own bit set. This shows that each enable picks exactly one strobe. The freeze bit is combined with an enabled strobe. The override order is checked by stacking a continuous force over a latched one-shot level and then removing it. Each of these patterns has an expected output that a wrong priority or a wrong load point would change.

// File: rtl/pwm_force_pkg.sv
package pwm_force_pkg;
  localparam int CTL_W      = 16;
  localparam int UPD_W      = 6;
  localparam int EV_N       = 5;
  localparam int FREEZE_BIT = 5;
  localparam int NCH        = 2;
  localparam int MODE_W     = 2;

  typedef enum logic [MODE_W-1:0] {
    FM_NONE  = 2'd0,
    FM_LOW   = 2'd1,
    FM_HIGH  = 2'd2,
    FM_NONE3 = 2'd3
  } fmode_e;

  // field positions, per channel
  function automatic int cmode_lsb(input int ch);
    return 6 + MODE_W * ch;
  endfunction

  function automatic int trig_bit(input int ch);
    return 10 + 3 * ch;
  endfunction

  function automatic int omode_lsb(input int ch);
    return 11 + 3 * ch;
  endfunction

  // mode decode
  function automatic logic fm_forces(input logic [MODE_W-1:0] m);
    return (m == FM_LOW) || (m == FM_HIGH);
  endfunction

  function automatic logic fm_level(input logic [MODE_W-1:0] m);
    return (m == FM_HIGH);
  endfunction
endpackage

// File: rtl/pwm_force_shadow.sv
module pwm_force_shadow
  import pwm_force_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [CTL_W-1:0]             wr_data,
  input  logic [EV_N-1:0]              ev,
  output logic [CTL_W-1:0]             ctl_q,
  output logic [NCH-1:0][MODE_W-1:0]   act_mode,
  output logic                         load_evt,
  output logic                         load_imm
);
  logic [CTL_W-1:0] ctl_nxt;
  logic [EV_N-1:0]  hits;
  logic             frozen;

  assign ctl_nxt  = wr_en ? wr_data : ctl_q;
  assign hits     = ev & ctl_q[EV_N-1:0];
  assign frozen   = ctl_q[FREEZE_BIT];
  assign load_imm = (ctl_nxt[UPD_W-1:0] == '0);
  assign load_evt = !frozen && (ctl_q[UPD_W-1:0] != '0) && (|hits);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (wr_en) begin
      ctl_q <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_mode <= '0;
    end else begin
      for (int ch = 0; ch < NCH; ch++) begin
        if (load_imm) begin
          act_mode[ch] <= ctl_nxt[cmode_lsb(ch) +: MODE_W];
        end else if (load_evt) begin
          act_mode[ch] <= ctl_q[cmode_lsb(ch) +: MODE_W];
        end
      end
    end
  end
endmodule

// File: rtl/pwm_force_trig.sv
module pwm_force_trig
  import pwm_force_pkg::*;
(
  input  logic              wr_en,
  input  logic              new_trig,
  input  logic              cur_trig,
  input  logic [MODE_W-1:0] new_mode,
  output logic              fire,
  output logic [MODE_W-1:0] fire_mode
);
  // an edge of the stored trigger bit, either direction
  assign fire      = wr_en && (new_trig != cur_trig);
  assign fire_mode = new_mode;
endmodule

// File: rtl/pwm_force_chan.sv
module pwm_force_chan
  import pwm_force_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gen,
  input  logic              fire,
  input  logic [MODE_W-1:0] fire_mode,
  input  logic [MODE_W-1:0] act_mode,
  output logic              state,
  output logic              pwm
);
  logic gen_prev;
  logic gen_moved;
  logic os_take;

  assign gen_moved = (gen != gen_prev);
  assign os_take   = fire && fm_forces(fire_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_prev <= 1'b0;
      state    <= 1'b0;
    end else begin
      gen_prev <= gen;
      if (os_take) begin
        state <= fm_level(fire_mode);
      end else if (gen_moved) begin
        state <= gen;
      end
    end
  end

  assign pwm = fm_forces(act_mode) ? fm_level(act_mode) : state;
endmodule

// File: rtl/pwm_force_ctrl.sv
module pwm_force_ctrl
  import pwm_force_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  input  logic        gen_a,
  input  logic        gen_b,
  input  logic        ev_zero,
  input  logic        ev_period,
  input  logic        ev_cmpa,
  input  logic        ev_cmpb,
  input  logic        ev_sync,
  output logic        pwm_a,
  output logic        pwm_b,
  output logic [15:0] rd_data
);
  logic [CTL_W-1:0]           ctl_q;
  logic [NCH-1:0][MODE_W-1:0] act_mode;
  logic [NCH-1:0][MODE_W-1:0] fire_mode;
  logic [NCH-1:0]             os_fire;
  logic [NCH-1:0]             gen_v;
  logic [NCH-1:0]             pwm_v;
  logic [NCH-1:0]             state_v;
  logic [EV_N-1:0]            ev_v;
  logic                       load_evt;
  logic                       load_imm;

  assign ev_v  = {ev_sync, ev_cmpb, ev_cmpa, ev_period, ev_zero};
  assign gen_v = {gen_b, gen_a};

  pwm_force_shadow u_shadow (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .ev       (ev_v),
    .ctl_q    (ctl_q),
    .act_mode (act_mode),
    .load_evt (load_evt),
    .load_imm (load_imm)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    pwm_force_trig u_trig (
      .wr_en     (wr_en),
      .new_trig  (wr_data[trig_bit(ch)]),
      .cur_trig  (ctl_q[trig_bit(ch)]),
      .new_mode  (wr_data[omode_lsb(ch) +: MODE_W]),
      .fire      (os_fire[ch]),
      .fire_mode (fire_mode[ch])
    );

    pwm_force_chan u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .gen       (gen_v[ch]),
      .fire      (os_fire[ch]),
      .fire_mode (fire_mode[ch]),
      .act_mode  (act_mode[ch]),
      .state     (state_v[ch]),
      .pwm       (pwm_v[ch])
    );
  end

  assign pwm_a   = pwm_v[0];
  assign pwm_b   = pwm_v[1];
  assign rd_data = ctl_q;
endmodule

// File: rtl/pwm_force_ctrl_chk.sv
module pwm_force_ctrl_chk
  import pwm_force_pkg::*;
(
  input logic                       clk,
  input logic                       rst_n,
  input logic                       wr_en,
  input logic [15:0]                wr_data,
  input logic [EV_N-1:0]            ev_v,
  input logic [15:0]                rd_data,
  input logic                       pwm_a,
  input logic                       pwm_b,
  input logic [NCH-1:0][MODE_W-1:0] act_mode,
  input logic [NCH-1:0]             os_fire
);
  assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == $past(wr_data));

  assert_cont_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode[0] == FM_LOW) |-> !pwm_a);

  assert_cont_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode[1] == FM_HIGH) |-> pwm_b);

  assert_fire_toggles_R4: assert property (@(posedge clk) disable iff (!rst_n)
    os_fire[0] |=> rd_data[10] != $past(rd_data[10]));

  assert_oneshot_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (os_fire[0] && wr_data[12:11] == 2'd2 && wr_data[5:0] == 6'd0 &&
     !fm_forces(wr_data[7:6])) |=> pwm_a);

  assert_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[5] && !wr_en) |=> $stable(act_mode));

  assert_no_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_data[5:0] != 6'd0) && !wr_en && ((ev_v & rd_data[4:0]) == '0))
      |=> $stable(act_mode));
endmodule

bind pwm_force_ctrl pwm_force_ctrl_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .ev_v     (ev_v),
  .rd_data  (rd_data),
  .pwm_a    (pwm_a),
  .pwm_b    (pwm_b),
  .act_mode (act_mode),
  .os_fire  (os_fire)
);

// File: tb/pwm_force_ctrl_tb_top.sv
module pwm_force_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        gen_a = 1'b0, gen_b = 1'b0;
  logic        ev_zero = 1'b0, ev_period = 1'b0, ev_cmpa = 1'b0;
  logic        ev_cmpb = 1'b0, ev_sync = 1'b0;
  logic        pwm_a, pwm_b;
  logic [15:0] rd_data;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pwm_force_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .gen_a(gen_a), .gen_b(gen_b), .ev_zero(ev_zero), .ev_period(ev_period),
    .ev_cmpa(ev_cmpa), .ev_cmpb(ev_cmpb), .ev_sync(ev_sync),
    .pwm_a(pwm_a), .pwm_b(pwm_b), .rd_data(rd_data)
  );

  // word builders (field positions from the requirements)
  function automatic logic [15:0] w_upd(input logic [5:0] u);
    return {10'd0, u};
  endfunction
  function automatic logic [15:0] w_cont(input logic [1:0] ma, input logic [1:0] mb);
    return (16'(ma) << 6) | (16'(mb) << 8);
  endfunction
  function automatic logic [15:0] w_os_a(input logic t, input logic [1:0] m);
    return (16'(t) << 10) | (16'(m) << 11);
  endfunction
  function automatic logic [15:0] w_os_b(input logic t, input logic [1:0] m);
    return (16'(t) << 13) | (16'(m) << 14);
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; gen_a = 1'b0; gen_b = 1'b0;
    {ev_sync, ev_cmpb, ev_cmpa, ev_period, ev_zero} = '0;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic wr(input logic [15:0] d);
    wr_en = 1'b1; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [4:0] v);
    {ev_sync, ev_cmpb, ev_cmpa, ev_period, ev_zero} = v;
    step();
    {ev_sync, ev_cmpb, ev_cmpa, ev_period, ev_zero} = '0;
  endtask

  task automatic set_gen(input logic a, input logic b);
    gen_a = a; gen_b = b;
    step();
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 readback zero", rd_data, 16'h0000);
    check("R1 outputs low", {14'd0, pwm_b, pwm_a}, 16'd0);
    set_gen(1'b1, 1'b0);
    check("R1 follows gen a", {15'd0, pwm_a}, 16'd1);
    set_gen(1'b0, 1'b1);
    check("R1 follows gen ab", {14'd0, pwm_b, pwm_a}, 16'd2);
  endtask

  task automatic t_readback();
    do_reset();
    wr(16'h5A3F);
    check("R2 readback", rd_data, 16'h5A3F);
    wr(16'h0000);
    check("R2 readback zero", rd_data, 16'h0000);
  endtask

  task automatic t_oneshot();
    do_reset();
    wr(w_os_a(1'b1, 2'd2));
    check("R4 rising toggle high", {15'd0, pwm_a}, 16'd1);
    step(); step();
    check("R5 level holds", {15'd0, pwm_a}, 16'd1);
    wr(w_os_a(1'b1, 2'd1));
    check("R4 same trigger no fire", {15'd0, pwm_a}, 16'd1);
    wr(w_os_a(1'b0, 2'd1));
    check("R4 falling toggle low", {15'd0, pwm_a}, 16'd0);
    set_gen(1'b1, 1'b0);
    check("R5 gen change takes over", {15'd0, pwm_a}, 16'd1);
    wr(w_os_a(1'b1, 2'd3));
    check("R3 mode 3 no force", {15'd0, pwm_a}, 16'd1);
    wr(w_os_a(1'b0, 2'd0));
    check("R3 mode 0 no force", {15'd0, pwm_a}, 16'd1);
    wr(w_os_b(1'b1, 2'd2));
    check("R4 channel b fires", {14'd0, pwm_b, pwm_a}, 16'd3);
  endtask

  task automatic t_immediate();
    do_reset();
    set_gen(1'b1, 1'b0);
    wr(w_cont(2'd1, 2'd2));
    check("R6 immediate low a high b", {14'd0, pwm_b, pwm_a}, 16'd2);
    wr(w_cont(2'd3, 2'd0));
    check("R3 modes 3 and 0 release", {14'd0, pwm_b, pwm_a}, 16'd1);
  endtask

  task automatic t_events();
    for (int i = 0; i < 5; i++) begin
      do_reset();
      set_gen(1'b1, 1'b0);
      wr(w_upd(6'(1 << i)) | w_cont(2'd1, 2'd0));
      check($sformatf("R11 shadow only, event %0d", i), {15'd0, pwm_a}, 16'd1);
      check("R11 readback shows shadow", rd_data, w_upd(6'(1 << i)) | w_cont(2'd1, 2'd0));
      pulse(5'(1 << ((i + 1) % 5)));
      check($sformatf("R7 other strobe ignored, event %0d", i), {15'd0, pwm_a}, 16'd1);
      pulse(5'(1 << i));
      check($sformatf("R7 enabled strobe loads, event %0d", i), {15'd0, pwm_a}, 16'd0);
    end
  endtask

  task automatic t_multi();
    do_reset();
    set_gen(1'b0, 1'b0);
    wr(w_upd(6'h03) | w_cont(2'd2, 2'd2));
    pulse(5'b00011);
    check("R8 coincident strobes load once", {14'd0, pwm_b, pwm_a}, 16'd3);
    wr(w_upd(6'h03) | w_cont(2'd1, 2'd0));
    check("R8 shadow pending", {14'd0, pwm_b, pwm_a}, 16'd3);
    pulse(5'b11111);
    check("R8 all strobes one load", {14'd0, pwm_b, pwm_a}, 16'd0);
  endtask

  task automatic t_freeze();
    do_reset();
    set_gen(1'b1, 1'b0);
    wr(w_upd(6'h21) | w_cont(2'd1, 2'd2));
    pulse(5'b00001);
    check("R9 freeze blocks load", {14'd0, pwm_b, pwm_a}, 16'd1);
    wr(w_upd(6'h01) | w_cont(2'd1, 2'd2));
    pulse(5'b00001);
    check("R9 load after unfreeze", {14'd0, pwm_b, pwm_a}, 16'd2);
    wr(w_upd(6'h3F) | w_cont(2'd0, 2'd0));
    pulse(5'b11111);
    check("R9 freeze wins over enables", {14'd0, pwm_b, pwm_a}, 16'd2);
  endtask

  task automatic t_priority();
    do_reset();
    set_gen(1'b1, 1'b0);
    wr(w_cont(2'd2, 2'd0));
    wr(w_cont(2'd2, 2'd0) | w_os_a(1'b1, 2'd1));
    check("R10 continuous over one-shot", {15'd0, pwm_a}, 16'd1);
    wr(w_os_a(1'b1, 2'd1));
    check("R10 release reveals latched low", {15'd0, pwm_a}, 16'd0);
    wr(w_cont(2'd1, 2'd0) | w_os_a(1'b1, 2'd1));
    set_gen(1'b0, 1'b0);
    set_gen(1'b1, 1'b0);
    check("R10 continuous over generator", {15'd0, pwm_a}, 16'd0);
  endtask

  initial begin
    t_reset();
    t_readback();
    t_oneshot();
    t_immediate();
    t_events();
    t_multi();
    t_freeze();
    t_priority();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule